// File: doc/BRIEF.md
# Single-Cycle CPU Main Control Decoder

This block is the main control decoder of a single-cycle 32-bit processor core. It looks at two fields of the instruction being executed: the 6-bit primary opcode and the 6-bit function field. From them it produces, in the same cycle and with no state, every steering signal the rest of the datapath needs. These cover the register-file write enable and the choice of destination register, the class of ALU operation and the ALU's second operand, and the data-memory read and write strobes. They also cover the load-result select, the branch enable with a condition code, and the flags that redirect the program counter.

Beyond loads, stores, immediate adds and generic register-register arithmetic, the decoder covers a multiply, four branch flavours and three forms of control transfer. The branch flavours are equal, not-equal (which also serves as branch-if-nonzero), less-or-equal and less-than-zero. The control transfers are an absolute jump, a jump that links the return address into register 31, and a jump to the address held in a source register. The comparison itself, the register file, the memories and the program counter live outside this block. An all-zero instruction is a no-operation, and any opcode outside the supported set leaves every write enable, branch and jump flag low.

Top module: `sc_ctl_decoder`

## Requirements
- R1: Opcode 6'h23 (load word) gives reg_wr=1, dst_sel=0 (rt), alu_class=0 (add), alu_src_imm=1, mem_rd=1, mem_to_reg=1, mem_wr=0, all branch and jump flags 0; the function field has no effect.
- R2: Opcode 6'h2B (store word) gives mem_wr=1, alu_class=0, alu_src_imm=1, reg_wr=0, mem_rd=0, mem_to_reg=0, no branch or jump.
- R3: Opcode 6'h02 gives jump=1 and nothing else. Opcode 6'h03 gives jump=1, link=1, reg_wr=1 and dst_sel=2 (register 31, written with PC+4).
- R4: Opcode 6'h00 with function 6'h08 gives jump_reg=1 (next PC from rs) with reg_wr=0 and jump=0.
- R5: Opcode 6'h00 with function 6'h18 gives reg_wr=1, dst_sel=1 (rd), alu_class=3 (multiply). Any other nonzero function other than 6'h08 gives reg_wr=1, dst_sel=1, alu_class=2 (operation from the function field).
- R6: Opcode 6'h04 gives branch=1 with br_cond=1 (rs == rt). Opcode 6'h05 gives branch=1 with br_cond=2 (rs != rt, rt=0 for the nonzero test). Both use alu_class=1 (subtract), alu_src_imm=0 and reg_wr=0.
- R7: Opcode 6'h06 gives branch=1 with br_cond=3 (rs <= rt). Opcode 6'h01 gives branch=1 with br_cond=4 (rs < 0). Both use alu_class=1 and reg_wr=0.
- R8: The all-zero instruction (opcode 0, function 0) drives every output to 0, in particular reg_wr=0 and mem_wr=0.
- R9: Opcodes 6'h08 (add immediate) and 6'h0F (load immediate) both give reg_wr=1, dst_sel=0, alu_class=0, alu_src_imm=1 and nothing else.
- R10: Every opcode not named in R1 to R9 drives all outputs to 0, whatever the function field holds.
- R11: At most one of branch, jump and jump_reg is high. mem_rd and mem_wr are never both high. br_cond is nonzero exactly when branch is high. mem_to_reg implies mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_opcode | input | 6 | Primary opcode, instruction bits 31:26 |
| i_funct | input | 6 | Function field, instruction bits 5:0 |
| o_reg_wr | output | 1 | Register-file write enable |
| o_dst_sel | output | 2 | Destination select: 0 rt, 1 rd, 2 register 31 |
| o_alu_class | output | 3 | ALU class: 0 add, 1 subtract, 2 from function, 3 multiply |
| o_alu_src_imm | output | 1 | ALU second operand is the sign-extended immediate |
| o_mem_rd | output | 1 | Data-memory read strobe |
| o_mem_wr | output | 1 | Data-memory write strobe |
| o_mem_to_reg | output | 1 | Register write data comes from memory |
| o_branch | output | 1 | Conditional branch instruction |
| o_br_cond | output | 3 | Condition: 0 none, 1 eq, 2 ne, 3 le, 4 less than zero |
| o_jump | output | 1 | Absolute jump to the 26-bit target |
| o_link | output | 1 | Write PC+4 into register 31 |
| o_jump_reg | output | 1 | Next PC taken from register rs |

## Verification
Two functions of this decoder fall in one decode: the register write and the program-counter redirect of the linking jump, and the opcode path and function path when opcode 0 shares a cycle with a function value that means jump-register, multiply or no-operation. The bench provokes the first by presenting opcode 6'h03 and requires reg_wr, link, jump and dst_sel=2 together in the same sample. It provokes the second by sweeping all 64 function values under opcode 0 and all 64 opcodes under two function values. Each result is judged against the full 17-bit control vector that the requirements predict.

// File: rtl/sc_ctl_pkg.sv
// Package: shared field widths, opcode/function values and output codes
// for the single-cycle control decoder. Assumes 6-bit opcode/function fields.
package sc_ctl_pkg;
    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int DST_W = 2;
    localparam int ALU_W = 3;
    localparam int BC_W  = 3;

    // Primary opcodes
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_BLTZ  = 6'h01;
    localparam logic [OP_W-1:0] OPC_J     = 6'h02;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;
    localparam logic [OP_W-1:0] OPC_BLE   = 6'h06;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_LI    = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
    localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;

    // Function field values under opcode 0
    localparam logic [FN_W-1:0] FN_NOP = 6'h00;
    localparam logic [FN_W-1:0] FN_JR  = 6'h08;
    localparam logic [FN_W-1:0] FN_MUL = 6'h18;

    typedef enum logic [DST_W-1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2
    } dst_sel_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_FN  = 3'd2,
        ALU_MUL = 3'd3
    } alu_class_e;

    typedef enum logic [BC_W-1:0] {
        BC_NONE = 3'd0,
        BC_EQ   = 3'd1,
        BC_NE   = 3'd2,
        BC_LE   = 3'd3,
        BC_LTZ  = 3'd4
    } br_cond_e;

    // One flag per recognised opcode; all low for an unknown opcode
    typedef struct packed {
        logic rtype;
        logic lw;
        logic sw;
        logic beq;
        logic bne;
        logic ble;
        logic bltz;
        logic addi;
        logic li;
        logic j;
        logic jal;
    } op_hit_t;
endpackage

// File: rtl/sc_op_class.sv
// Module: classifies the primary opcode into one flag per supported
// instruction kind. Assumes nothing about the function field.
module sc_op_class
    import sc_ctl_pkg::*;
(
    input  logic [OP_W-1:0] i_opcode,
    output op_hit_t         o_hit
);
    // Opcode lookup: at most one flag set, none for unknown opcodes
    always_comb begin
        o_hit = '0;
        unique case (i_opcode)
            OPC_RTYPE: o_hit.rtype = 1'b1;
            OPC_LW:    o_hit.lw    = 1'b1;
            OPC_SW:    o_hit.sw    = 1'b1;
            OPC_BEQ:   o_hit.beq   = 1'b1;
            OPC_BNE:   o_hit.bne   = 1'b1;
            OPC_BLE:   o_hit.ble   = 1'b1;
            OPC_BLTZ:  o_hit.bltz  = 1'b1;
            OPC_ADDI:  o_hit.addi  = 1'b1;
            OPC_LI:    o_hit.li    = 1'b1;
            OPC_J:     o_hit.j     = 1'b1;
            OPC_JAL:   o_hit.jal   = 1'b1;
            default:   o_hit       = '0;
        endcase
    end
endmodule

// File: rtl/sc_funct_class.sv
// Module: splits register-register instructions by function field into
// jump-register, multiply and generic arithmetic. Function 0 is the
// no-operation and raises none of the flags. Only meaningful when the
// opcode is 0; the enable input gates all flags.
module sc_funct_class
    import sc_ctl_pkg::*;
(
    input  logic            i_en,
    input  logic [FN_W-1:0] i_funct,
    output logic            o_jr,
    output logic            o_mul,
    output logic            o_gen
);
    // Function lookup, gated by the register-register opcode
    always_comb begin
        o_jr  = 1'b0;
        o_mul = 1'b0;
        o_gen = 1'b0;
        if (i_en) begin
            unique case (i_funct)
                FN_NOP:  ;
                FN_JR:   o_jr  = 1'b1;
                FN_MUL:  o_mul = 1'b1;
                default: o_gen = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sc_branch_sel.sv
// Module: turns the branch opcode flags into a branch enable and a
// condition code for the comparator outside this block.
module sc_branch_sel
    import sc_ctl_pkg::*;
(
    input  op_hit_t         i_hit,
    output logic            o_branch,
    output logic [BC_W-1:0] o_cond
);
    // Condition code per branch kind; none when not a branch
    always_comb begin
        o_cond = BC_NONE;
        if (i_hit.beq)  o_cond = BC_EQ;
        if (i_hit.bne)  o_cond = BC_NE;
        if (i_hit.ble)  o_cond = BC_LE;
        if (i_hit.bltz) o_cond = BC_LTZ;
    end

    // Branch enable from the same flags
    always_comb o_branch = i_hit.beq | i_hit.bne | i_hit.ble | i_hit.bltz;
endmodule

// File: rtl/sc_ctl_decoder.sv
// Module: main control decoder of a single-cycle core. Purely
// combinational: opcode and function field in, full control vector out.
// Assumes the comparator, register file, memories and PC logic are outside.
module sc_ctl_decoder
    import sc_ctl_pkg::*;
(
    input  logic [OP_W-1:0]  i_opcode,
    input  logic [FN_W-1:0]  i_funct,
    output logic             o_reg_wr,
    output logic [DST_W-1:0] o_dst_sel,
    output logic [ALU_W-1:0] o_alu_class,
    output logic             o_alu_src_imm,
    output logic             o_mem_rd,
    output logic             o_mem_wr,
    output logic             o_mem_to_reg,
    output logic             o_branch,
    output logic [BC_W-1:0]  o_br_cond,
    output logic             o_jump,
    output logic             o_link,
    output logic             o_jump_reg
);
    op_hit_t hit;
    logic    fn_jr, fn_mul, fn_gen;
    logic    rr_write, imm_write, mem_op;

    sc_op_class u_op (
        .i_opcode (i_opcode),
        .o_hit    (hit)
    );

    sc_funct_class u_fn (
        .i_en    (hit.rtype),
        .i_funct (i_funct),
        .o_jr    (fn_jr),
        .o_mul   (fn_mul),
        .o_gen   (fn_gen)
    );

    sc_branch_sel u_br (
        .i_hit    (hit),
        .o_branch (o_branch),
        .o_cond   (o_br_cond)
    );

    // Group terms shared by several outputs
    always_comb begin
        rr_write  = fn_mul | fn_gen;
        imm_write = hit.addi | hit.li;
        mem_op    = hit.lw | hit.sw;
    end

    // Register-file write enable and destination select
    always_comb begin
        o_reg_wr  = rr_write | imm_write | hit.lw | hit.jal;
        o_dst_sel = DST_RT;
        if (rr_write) o_dst_sel = DST_RD;
        if (hit.jal)  o_dst_sel = DST_LINK;
    end

    // ALU class and operand source
    always_comb begin
        o_alu_class = ALU_ADD;
        if (o_branch) o_alu_class = ALU_SUB;
        if (fn_gen)   o_alu_class = ALU_FN;
        if (fn_mul)   o_alu_class = ALU_MUL;
        o_alu_src_imm = mem_op | imm_write;
    end

    // Memory strobes and load-result select
    always_comb begin
        o_mem_rd     = hit.lw;
        o_mem_wr     = hit.sw;
        o_mem_to_reg = hit.lw;
    end

    // Program-counter redirect flags
    always_comb begin
        o_jump     = hit.j | hit.jal;
        o_link     = hit.jal;
        o_jump_reg = fn_jr;
    end
endmodule

// File: rtl/sc_ctl_decoder_chk.sv
// Module: assertion checker for the control decoder, attached by bind.
// Uses immediate assertions because the block has no clock.
module sc_ctl_decoder_chk
    import sc_ctl_pkg::*;
(
    input logic [OP_W-1:0]  i_opcode,
    input logic [FN_W-1:0]  i_funct,
    input logic             o_reg_wr,
    input logic [DST_W-1:0] o_dst_sel,
    input logic [ALU_W-1:0] o_alu_class,
    input logic             o_alu_src_imm,
    input logic             o_mem_rd,
    input logic             o_mem_wr,
    input logic             o_mem_to_reg,
    input logic             o_branch,
    input logic [BC_W-1:0]  o_br_cond,
    input logic             o_jump,
    input logic             o_link,
    input logic             o_jump_reg
);
    // Output consistency checks across the sub-decoders
    always_comb begin
        p_flow_onehot_r11: assert ($onehot0({o_branch, o_jump, o_jump_reg}));
        p_mem_excl_r11: assert (!(o_mem_rd && o_mem_wr));
        p_cond_iff_branch_r11: assert (o_branch == (o_br_cond != BC_NONE));
        p_m2r_needs_rd_r11: assert (!o_mem_to_reg || o_mem_rd);
        p_nop_quiet_r8: assert (!(i_opcode == '0 && i_funct == '0) ||
                                (!o_reg_wr && !o_mem_wr && !o_jump_reg));
        p_link_shape_r3: assert (!o_link || (o_reg_wr && o_jump && o_dst_sel == DST_LINK));
        p_jr_no_write_r4: assert (!o_jump_reg || !o_reg_wr);
        p_branch_no_write_r6: assert (!o_branch || (!o_reg_wr && !o_alu_src_imm &&
                                      o_alu_class == ALU_SUB));
    end
endmodule

bind sc_ctl_decoder sc_ctl_decoder_chk u_chk (.*);

// File: tb/tb_sc_ctl_decoder.sv
// Bench: table of encodings with expected control vectors, then sweeps
// of all opcodes and all function values.
module tb_sc_ctl_decoder;
    import sc_ctl_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [5:0] opcode, funct;
    logic       reg_wr, alu_src_imm, mem_rd, mem_wr, mem_to_reg, branch, jump, link, jump_reg;
    logic [1:0] dst_sel;
    logic [2:0] alu_class, br_cond;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sc_ctl_decoder dut (
        .i_opcode(opcode), .i_funct(funct),
        .o_reg_wr(reg_wr), .o_dst_sel(dst_sel), .o_alu_class(alu_class),
        .o_alu_src_imm(alu_src_imm), .o_mem_rd(mem_rd), .o_mem_wr(mem_wr),
        .o_mem_to_reg(mem_to_reg), .o_branch(branch), .o_br_cond(br_cond),
        .o_jump(jump), .o_link(link), .o_jump_reg(jump_reg)
    );

    // Expected vector: rw, dst[2], alu[3], imm, mrd, mwr, m2r, br, cond[3], j, lnk, jr
    function automatic logic [16:0] mk(input logic rw, input logic [1:0] dst,
            input logic [2:0] alu, input logic imm, input logic mrd,
            input logic mwr, input logic m2r, input logic br,
            input logic [2:0] bc, input logic j, input logic lnk, input logic jr);
        return {rw, dst, alu, imm, mrd, mwr, m2r, br, bc, j, lnk, jr};
    endfunction

    localparam int N = 19;
    // Entry: req[3:0], opcode[5:0], funct[5:0], expected[16:0]
    localparam logic [32:0] VEC [N] = '{
        {4'd1,  6'h23, 6'h00, mk(1,0,0,1,1,0,1,0,0,0,0,0)}, // R1 load
        {4'd1,  6'h23, 6'h3F, mk(1,0,0,1,1,0,1,0,0,0,0,0)}, // R1 funct ignored
        {4'd2,  6'h2B, 6'h00, mk(0,0,0,1,0,1,0,0,0,0,0,0)}, // R2 store
        {4'd3,  6'h02, 6'h00, mk(0,0,0,0,0,0,0,0,0,1,0,0)}, // R3 jump
        {4'd3,  6'h03, 6'h08, mk(1,2,0,0,0,0,0,0,0,1,1,0)}, // R3 jump and link
        {4'd4,  6'h00, 6'h08, mk(0,0,0,0,0,0,0,0,0,0,0,1)}, // R4 jump register
        {4'd5,  6'h00, 6'h18, mk(1,1,3,0,0,0,0,0,0,0,0,0)}, // R5 multiply
        {4'd5,  6'h00, 6'h21, mk(1,1,2,0,0,0,0,0,0,0,0,0)}, // R5 add unsigned
        {4'd5,  6'h00, 6'h23, mk(1,1,2,0,0,0,0,0,0,0,0,0)}, // R5 subtract unsigned
        {4'd6,  6'h04, 6'h00, mk(0,0,1,0,0,0,0,1,1,0,0,0)}, // R6 equal
        {4'd6,  6'h05, 6'h00, mk(0,0,1,0,0,0,0,1,2,0,0,0)}, // R6 not equal
        {4'd7,  6'h06, 6'h00, mk(0,0,1,0,0,0,0,1,3,0,0,0)}, // R7 less or equal
        {4'd7,  6'h01, 6'h00, mk(0,0,1,0,0,0,0,1,4,0,0,0)}, // R7 less than zero
        {4'd8,  6'h00, 6'h00, mk(0,0,0,0,0,0,0,0,0,0,0,0)}, // R8 no-operation
        {4'd9,  6'h08, 6'h00, mk(1,0,0,1,0,0,0,0,0,0,0,0)}, // R9 add immediate
        {4'd9,  6'h0F, 6'h00, mk(1,0,0,1,0,0,0,0,0,0,0,0)}, // R9 load immediate
        {4'd10, 6'h3F, 6'h08, mk(0,0,0,0,0,0,0,0,0,0,0,0)}, // R10 unknown
        {4'd10, 6'h2E, 6'h18, mk(0,0,0,0,0,0,0,0,0,0,0,0)}, // R10 unknown
        {4'd10, 6'h07, 6'h00, mk(0,0,0,0,0,0,0,0,0,0,0,0)}  // R10 unknown
    };

    // Requirement-level expectation used by the sweeps
    function automatic logic [16:0] expect_of(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'h00: begin
                if (fn == 6'h00) return mk(0,0,0,0,0,0,0,0,0,0,0,0);
                if (fn == 6'h08) return mk(0,0,0,0,0,0,0,0,0,0,0,1);
                if (fn == 6'h18) return mk(1,1,3,0,0,0,0,0,0,0,0,0);
                return mk(1,1,2,0,0,0,0,0,0,0,0,0);
            end
            6'h23: return mk(1,0,0,1,1,0,1,0,0,0,0,0);
            6'h2B: return mk(0,0,0,1,0,1,0,0,0,0,0,0);
            6'h02: return mk(0,0,0,0,0,0,0,0,0,1,0,0);
            6'h03: return mk(1,2,0,0,0,0,0,0,0,1,1,0);
            6'h04: return mk(0,0,1,0,0,0,0,1,1,0,0,0);
            6'h05: return mk(0,0,1,0,0,0,0,1,2,0,0,0);
            6'h06: return mk(0,0,1,0,0,0,0,1,3,0,0,0);
            6'h01: return mk(0,0,1,0,0,0,0,1,4,0,0,0);
            6'h08, 6'h0F: return mk(1,0,0,1,0,0,0,0,0,0,0,0);
            default: return '0;
        endcase
    endfunction

    // Drive on the falling edge, sample mid-low-phase, compare
    task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                         input logic [16:0] exp, input int req);
        logic [16:0] got;
        @(negedge clk);
        opcode = op;
        funct  = fn;
        #5;
        got = {reg_wr, dst_sel, alu_class, alu_src_imm, mem_rd, mem_wr,
               mem_to_reg, branch, br_cond, jump, link, jump_reg};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d op=%h fn=%h actual=%h expected=%h", req, op, fn, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main stimulus
    initial begin
        opcode = '0;
        funct  = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero instruction gives a quiet vector (R8)
        apply(6'h00, 6'h00, '0, 8);
        // Table walk (R1..R10)
        for (int k = 0; k < N; k++)
            apply(VEC[k][28:23], VEC[k][22:17], VEC[k][16:0], int'(VEC[k][32:29]));
        // Every function value under opcode 0 (R4, R5, R8)
        for (int f = 0; f < 64; f++)
            apply(6'h00, 6'(f), expect_of(6'h00, 6'(f)), 5);
        // Every opcode with two function values; non-zero opcodes ignore funct (R10)
        for (int o = 1; o < 64; o++) begin
            apply(6'(o), 6'h00, expect_of(6'(o), 6'h00), 10);
            apply(6'(o), 6'h18, expect_of(6'(o), 6'h18), 10);
        end
        // Back-to-back link jump then store: no carry-over between decodes (R3, R2)
        apply(6'h03, 6'h00, mk(1,2,0,0,0,0,0,0,0,1,1,0), 3);
        apply(6'h2B, 6'h08, mk(0,0,0,1,0,1,0,0,0,0,0,0), 2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule